// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns parallel characters into frames on an asynchronous serial line whose format is chosen at run time. A character enters over a valid/ready write port and is held in a one-entry holding register. When the serializer is free it moves the character into its own shift register. This lets one character wait while another is on the line. Bit timing comes from an external baud tick that pulses once per oversampled sub-bit period. With the default oversampling of 16, every start, data and parity bit lasts 16 ticks.

Three configuration inputs set the frame format:
- the character length, 5 to 8 bits;
- the parity mode: none, even, odd, or a fixed level taken from a separate input, which can serve as an address/data marker;
- the stop length: one, one-and-a-half or two bit periods.

The format is captured together with the character when it moves into the serializer. Changing the configuration therefore never disturbs a frame already on the line. The ready output doubles as a request that can feed an interrupt or DMA controller. The empty output shows that the whole transmit path has drained.

Top module: `uart_tx`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop time. Start, data and parity bits each last OVERSAMPLE baud ticks, and the line changes only on a baud tick or when a frame is loaded.
- R2: `cfg_len` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits of `wr_data` above the selected length are not sent.
- R3: With `cfg_parity` = 1 (even), the parity bit makes the count of ones over data plus parity even. With `cfg_parity` = 2 (odd), it makes that count odd.
- R4: With `cfg_parity` = 0, no parity bit is sent. With `cfg_parity` = 3, the parity bit equals `cfg_mark`.
- R5: `cfg_stop` selects the stop time: 0 = OVERSAMPLE ticks, 1 = 1.5 x OVERSAMPLE ticks (24 at the default), 2 or 3 = 2 x OVERSAMPLE ticks. The line stays high for the whole stop time.
- R6: A character written while another is being shifted waits in the holding register. Its start bit begins on the same tick that ends the previous frame's stop time.
- R7: `wr_ready` is high exactly when the holding register is empty. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low in the following cycle.
- R8: A write presented while the holding register is full is dropped and never transmitted. `wr_overrun` pulses high for one cycle, in the cycle after that write.
- R9: `tx_empty` is high only when both the holding register and the shift register are empty. Whenever it is high, `txd` is high and `wr_ready` is high.
- R10: The frame format is latched when a character enters the shift register. Changes to `cfg_*` after that point do not alter the frame in progress.
- R11: After reset, `txd` = 1, `wr_ready` = 1, `tx_empty` = 1 and `wr_overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at the oversampled bit rate |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 fixed |
| cfg_mark | input | 1 | Parity level used in fixed-parity mode |
| cfg_stop | input | 2 | Stop length: 0 one, 1 one-and-a-half, 2/3 two bit periods |
| wr_valid | input | 1 | Character write request |
| wr_data | input | 8 | Character to send, LSB first |
| wr_ready | output | 1 | Holding register empty; write accepted when high; service request |
| wr_overrun | output | 1 | One-cycle pulse after a write was dropped |
| tx_empty | output | 1 | Holding and shift registers both empty |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with the default OVERSAMPLE of 16 and pulses the baud tick every second clock. A one-and-a-half stop period therefore comes out as exactly 24 ticks. This is the only setting that shows whether the half-bit is counted exactly, rather than rounded to one or two bit periods. The full frame sweep is also short enough to cover every length, parity mode and stop length, including back-to-back frames. The monitor samples each bit at its tick-counted centre and measures start-to-start spacing in ticks. A stop time that is too long or too short therefore shows up as a changed spacing, not only as a wrong bit value.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

    localparam int unsigned CHAR_MAX_W = 8;
    localparam int unsigned BITCNT_W   = $clog2(CHAR_MAX_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_FIXED = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE     = 2'b00,
        STOP_ONEHALF = 2'b01,
        STOP_TWO     = 2'b10,
        STOP_TWO_ALT = 2'b11
    } stop_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] len_code;
        par_mode_e  par;
        logic       mark;
        stop_mode_e stop;
    } fmt_cfg_t;

    typedef struct packed {
        logic [CHAR_MAX_W-1:0] data;
        logic [BITCNT_W-1:0]   nbits;
        logic                  has_par;
        logic                  par_bit;
        stop_mode_e            stop;
    } frame_t;

    function automatic logic [BITCNT_W-1:0] char_bits(input logic [1:0] code);
        return BITCNT_W'(5) + BITCNT_W'(code);
    endfunction

    function automatic logic [CHAR_MAX_W-1:0] char_mask(input logic [1:0] code);
        return {CHAR_MAX_W{1'b1}} >> (2'd3 - code);
    endfunction

    function automatic logic parity_value(input logic [CHAR_MAX_W-1:0] d,
                                          input fmt_cfg_t cfg);
        logic ones_odd;
        ones_odd = ^(d & char_mask(cfg.len_code));
        case (cfg.par)
            PAR_EVEN:  return ones_odd;
            PAR_ODD:   return ~ones_odd;
            PAR_FIXED: return cfg.mark;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold
    import uart_tx_pkg::*;
#(
    parameter int unsigned W = CHAR_MAX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         wr_ready,
    output logic         full,
    output logic [W-1:0] data,
    output logic         overrun
);

    logic         full_q;
    logic [W-1:0] data_q;
    logic         ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            ovr_q <= wr_valid && full_q;
            if (wr_valid && !full_q) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign wr_ready = !full_q;
    assign full     = full_q;
    assign data     = data_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/uart_tx_prep.sv
`timescale 1ns/1ps
module uart_tx_prep
    import uart_tx_pkg::*;
(
    input  logic [CHAR_MAX_W-1:0] data,
    input  fmt_cfg_t              cfg,
    output frame_t                frame
);

    always_comb begin
        frame.data    = data & char_mask(cfg.len_code);
        frame.nbits   = char_bits(cfg.len_code);
        frame.has_par = (cfg.par != PAR_NONE);
        frame.par_bit = parity_value(data, cfg);
        frame.stop    = cfg.stop;
    end

endmodule

// File: rtl/uart_tx_shift.sv
`timescale 1ns/1ps
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   baud_tick,
    input  logic   frame_avail,
    input  frame_t frame_in,
    output logic   take,
    output logic   busy,
    output logic   txd
);

    localparam int unsigned T_ONE  = OVERSAMPLE;
    localparam int unsigned T_HALF = OVERSAMPLE + OVERSAMPLE / 2;
    localparam int unsigned T_TWO  = 2 * OVERSAMPLE;
    localparam int unsigned CW     = $clog2(T_TWO + 1);

    phase_e                phase_q;
    frame_t                fr_q;
    logic [CHAR_MAX_W-1:0] sh_q;
    logic [BITCNT_W-1:0]   idx_q;
    logic [CW-1:0]         tcnt_q;
    logic                  txd_q;

    logic [CW-1:0] bit_len;
    logic          last_tick;

    always_comb begin
        if (phase_q == PH_STOP) begin
            case (fr_q.stop)
                STOP_ONE:     bit_len = CW'(T_ONE);
                STOP_ONEHALF: bit_len = CW'(T_HALF);
                default:      bit_len = CW'(T_TWO);
            endcase
        end else begin
            bit_len = CW'(T_ONE);
        end
    end

    assign last_tick = baud_tick && (tcnt_q == bit_len - CW'(1));
    assign take      = frame_avail &&
                       ((phase_q == PH_IDLE) || (phase_q == PH_STOP && last_tick));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            fr_q    <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            tcnt_q  <= '0;
            txd_q   <= 1'b1;
        end else if (take) begin
            phase_q <= PH_START;
            fr_q    <= frame_in;
            sh_q    <= frame_in.data;
            idx_q   <= '0;
            tcnt_q  <= '0;
            txd_q   <= 1'b0;
        end else if (phase_q != PH_IDLE && baud_tick) begin
            if (last_tick) begin
                tcnt_q <= '0;
                case (phase_q)
                    PH_START: begin
                        phase_q <= PH_DATA;
                        txd_q   <= sh_q[0];
                    end
                    PH_DATA: begin
                        if (idx_q == fr_q.nbits - BITCNT_W'(1)) begin
                            if (fr_q.has_par) begin
                                phase_q <= PH_PARITY;
                                txd_q   <= fr_q.par_bit;
                            end else begin
                                phase_q <= PH_STOP;
                                txd_q   <= 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + BITCNT_W'(1);
                            sh_q  <= sh_q >> 1;
                            txd_q <= sh_q[1];
                        end
                    end
                    PH_PARITY: begin
                        phase_q <= PH_STOP;
                        txd_q   <= 1'b1;
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        txd_q   <= 1'b1;
                    end
                endcase
            end else begin
                tcnt_q <= tcnt_q + CW'(1);
            end
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign txd  = txd_q;

endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  baud_tick,
    input  logic [1:0]            cfg_len,
    input  logic [1:0]            cfg_parity,
    input  logic                  cfg_mark,
    input  logic [1:0]            cfg_stop,
    input  logic                  wr_valid,
    input  logic [CHAR_MAX_W-1:0] wr_data,
    output logic                  wr_ready,
    output logic                  wr_overrun,
    output logic                  tx_empty,
    output logic                  txd
);

    fmt_cfg_t              cfg;
    frame_t                frame;
    logic                  hold_full;
    logic [CHAR_MAX_W-1:0] hold_data;
    logic                  take;
    logic                  busy;

    always_comb begin
        cfg.len_code = cfg_len;
        cfg.par      = par_mode_e'(cfg_parity);
        cfg.mark     = cfg_mark;
        cfg.stop     = stop_mode_e'(cfg_stop);
    end

    uart_tx_hold #(.W(CHAR_MAX_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .wr_ready (wr_ready),
        .full     (hold_full),
        .data     (hold_data),
        .overrun  (wr_overrun)
    );

    uart_tx_prep u_prep (
        .data  (hold_data),
        .cfg   (cfg),
        .frame (frame)
    );

    uart_tx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .baud_tick   (baud_tick),
        .frame_avail (hold_full),
        .frame_in    (frame),
        .take        (take),
        .busy        (busy),
        .txd         (txd)
    );

    assign tx_empty = !hold_full && !busy;

endmodule

// File: rtl/uart_tx_checker.sv
`timescale 1ns/1ps
module uart_tx_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic wr_valid,
    input logic wr_ready,
    input logic wr_overrun,
    input logic tx_empty,
    input logic txd,
    input logic busy
);

    a_r1_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        busy && !baud_tick |=> $stable(txd));

    a_r9_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);

    a_r9_empty_means_ready: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> wr_ready);

    a_r7_accept_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready |=> !wr_ready);

    a_r8_drop_flagged: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_overrun);

    a_r8_no_false_flag: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && !wr_ready) |=> !wr_overrun);

endmodule

bind uart_tx uart_tx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_overrun (wr_overrun),
    .tx_empty   (tx_empty),
    .txd        (txd),
    .busy       (busy)
);

// File: tb/uart_tx_tb.sv
`timescale 1ns/1ps
module uart_tx_tb;

    localparam int OS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_mark = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready, wr_overrun, tx_empty, txd;

    int n_tests = 0;
    int n_fail  = 0;
    int tc      = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic [1:0] par;
        logic       mark;
        logic [1:0] stop;
    } exp_t;

    exp_t q[$];
    int   starts[$];

    uart_tx #(.OVERSAMPLE(OS)) u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_mark(cfg_mark),
        .cfg_stop(cfg_stop), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_overrun(wr_overrun), .tx_empty(tx_empty),
        .txd(txd)
    );

    always #10 clk = ~clk;

    always @(negedge clk) baud_tick <= ~baud_tick;

    always @(posedge clk) begin
        if (rst) tc <= 0;
        else if (baud_tick) tc <= tc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_tick(input int t);
        while (tc < t) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic [1:0] p,
                           input logic m, input logic [1:0] s);
        cfg_len = l; cfg_parity = p; cfg_mark = m; cfg_stop = s;
    endtask

    task automatic send(input logic [7:0] d);
        exp_t e;
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        e.d = d; e.len = cfg_len; e.par = cfg_parity; e.mark = cfg_mark; e.stop = cfg_stop;
        q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic handle_frame();
        exp_t e;
        int   t0, n, p, st, ss, ee, ones, mask;
        logic pv;
        logic [7:0] got;
        bit   ok;
        string preq;
        t0 = tc;
        if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected frame", 1, 0);
            e.d = 0; e.len = 3; e.par = 0; e.mark = 0; e.stop = 0;
        end else begin
            e = q.pop_front();
        end
        n    = 5 + int'(e.len);
        p    = (e.par != 2'd0) ? 1 : 0;
        mask = (1 << n) - 1;
        ones = $countones(int'(e.d) & mask);
        case (e.par)
            2'd1:    pv = ones[0];
            2'd2:    pv = ~ones[0];
            default: pv = e.mark;
        endcase
        st   = (e.stop == 2'd0) ? OS : (e.stop == 2'd1) ? OS + OS / 2 : 2 * OS;
        preq = (e.par == 2'd3) ? "R4" : "R3";
        starts.push_back(t0);
        wait_tick(t0 + OS / 2);
        check(txd == 1'b0, "R1", "start bit level", int'(txd), 0);
        got = 8'h00;
        for (int i = 0; i < n; i++) begin
            wait_tick(t0 + OS * (1 + i) + OS / 2);
            got[i] = txd;
        end
        check(int'(got) == (int'(e.d) & mask), "R2", "data bits LSB first",
              int'(got), int'(e.d) & mask);
        if (p == 1) begin
            wait_tick(t0 + OS * (1 + n) + OS / 2);
            check(txd == pv, preq, "parity bit", int'(txd), int'(pv));
        end
        ss = t0 + OS * (1 + n + p);
        ee = ss + st;
        wait_tick(ss);
        ok = 1'b1;
        while (tc < ee) begin
            if (txd !== 1'b1) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R5", "line high through stop time", int'(ok), 1);
    endtask

    initial begin : monitor
        bit prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            while (!rst && txd === 1'b0 && prev) handle_frame();
            prev = txd;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        int ns;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(txd == 1'b1, "R11", "txd after reset", int'(txd), 1);
        check(wr_ready == 1'b1, "R11", "wr_ready after reset", int'(wr_ready), 1);
        check(tx_empty == 1'b1, "R11", "tx_empty after reset", int'(tx_empty), 1);
        check(wr_overrun == 1'b0, "R11", "wr_overrun after reset", int'(wr_overrun), 0);

        // R1 R2: 8 bits, no parity, one stop
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0);
        send(8'hA5);
        wait_idle();
        // R2 R3: 5 bits even parity, upper bits dropped
        set_cfg(2'd0, 2'd1, 1'b0, 2'd0);
        send(8'hFB);
        wait_idle();
        // R3: 6 bits odd parity, two stop
        set_cfg(2'd1, 2'd2, 1'b0, 2'd2);
        send(8'h2D);
        wait_idle();
        // R4: 7 bits fixed parity 1 and 0, one-and-a-half stop
        set_cfg(2'd2, 2'd3, 1'b1, 2'd1);
        send(8'h55);
        wait_idle();
        set_cfg(2'd2, 2'd3, 1'b0, 2'd1);
        send(8'h7F);
        wait_idle();

        // R6 R7 R8 R9 R5: double buffering with 1.5 stop bits
        set_cfg(2'd3, 2'd1, 1'b0, 2'd1);
        send(8'h81);
        check(wr_ready == 1'b0, "R7", "ready low after accept", int'(wr_ready), 0);
        @(negedge clk);
        check(wr_ready == 1'b1, "R7", "ready back after move", int'(wr_ready), 1);
        check(tx_empty == 1'b0, "R9", "not empty while shifting", int'(tx_empty), 0);
        send(8'h42);
        check(tx_empty == 1'b0, "R9", "not empty with both full", int'(tx_empty), 0);
        wr_valid = 1'b1;
        wr_data  = 8'hEE;
        @(negedge clk);
        wr_valid = 1'b0;
        check(wr_overrun == 1'b1, "R8", "overrun pulse", int'(wr_overrun), 1);
        @(negedge clk);
        check(wr_overrun == 1'b0, "R8", "overrun one cycle", int'(wr_overrun), 0);
        wait_idle();
        ns = starts.size();
        check(starts[ns-1] - starts[ns-2] == OS * 10 + 24, "R6",
              "back-to-back spacing 1.5 stop", starts[ns-1] - starts[ns-2], OS * 10 + 24);
        check(q.size() == 0, "R8", "dropped write never sent", q.size(), 0);
        check(txd == 1'b1 && tx_empty == 1'b1, "R9", "drained line and empty",
              int'({txd, tx_empty}), 3);

        // R5: two stop bits back to back, 5 bits no parity
        set_cfg(2'd0, 2'd0, 1'b0, 2'd2);
        send(8'h13);
        send(8'h0C);
        wait_idle();
        ns = starts.size();
        check(starts[ns-1] - starts[ns-2] == OS * 6 + 2 * OS, "R5",
              "spacing two stop", starts[ns-1] - starts[ns-2], OS * 6 + 2 * OS);

        // R5: one stop back to back, 8 bits odd parity
        set_cfg(2'd3, 2'd2, 1'b0, 2'd0);
        send(8'h00);
        send(8'hFF);
        wait_idle();
        ns = starts.size();
        check(starts[ns-1] - starts[ns-2] == OS * 10 + OS, "R5",
              "spacing one stop", starts[ns-1] - starts[ns-2], OS * 10 + OS);

        // R10: config change after load leaves frame unchanged
        set_cfg(2'd3, 2'd0, 1'b0, 2'd0);
        send(8'h96);
        repeat (3) @(negedge clk);
        set_cfg(2'd0, 2'd1, 1'b1, 2'd2);
        wait_idle();
        ns = starts.size();
        check(q.size() == 0 && ns == 12, "R10", "frames delivered", ns, 12);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule